// File: doc/BRIEF.md
# Scrypt Memory-Hard Mixing Sequencer

This block runs the memory-hard core of scrypt: the mixing pass with a cost of N = 1024 and a block size of one 1024-bit block. It does not contain the block-mixing function. It drives an external mixing engine through a start/done handshake, and it owns a 1024-bit-wide on-chip scratchpad together with the state machine, address generation and XOR datapath that sit around that scratchpad.

A run begins with a start strobe and a 1024-bit input block. In the first phase the engine is applied N times in a chain, and the state present before each step is saved to the scratchpad. In the second phase the block does N data-dependent iterations. In each one it picks an index from the current state, reads the matching saved word, XORs that word into the state and applies the engine once more. When the last iteration ends, the final state appears on the output together with a one-cycle done pulse.

A build parameter selects the scratchpad size. The full size holds all N entries. The half size holds only the even-indexed entries. When an odd entry is needed, it is rebuilt by one extra engine pass on its even neighbour. This halves the RAM at the cost of about a quarter more engine passes, which suits devices that run out of RAM before they run out of logic. Both sizes give the same result.

Top module: `scrypt_romix_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `done` and `mix_start` are 0 and `blk_out` is all zeros.
- R2: `start` is accepted only while the block is idle, and `blk_in` is captured in that cycle. A `start` pulse during a run has no effect on that run's result.
- R3: The fill phase issues exactly N engine passes, whatever the scratchpad size. Each pass is given the state that is saved for that index. In full size, entry i is stored at address i.
- R4: In half size, the fill phase stores the state only for even i, at address i/2.
- R5: The read index j is bits [BLK_W/2 + N_LOG2 - 1 : BLK_W/2] of the current state. These are the low 10 bits of 32-bit word 16 when 32-bit word k occupies bits [32k+31:32k].
- R6: The read phase performs N iterations. Each iteration sets the state to engine(state XOR entry j). The final state is driven on `blk_out` and equals a software model of the same computation.
- R7: In half size, an odd j reads address (j-1)/2 and applies one extra engine pass to that word before using it. An even j reads address j/2. A run therefore issues 2N plus the number of odd indices engine passes in half size, and exactly 2N in full size.
- R8: For the same input, the full and half sizes produce identical `blk_out`.
- R9: `done` is high for exactly one cycle. `blk_out` changes only in the cycle in which `done` rises, and holds its value until the next completion.
- R10: `mix_start` is a one-cycle pulse, and it is never raised again until the engine has answered the previous pass with `mix_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; honoured only when idle |
| blk_in | input | BLK_W | Input block captured with `start` |
| done | output | 1 | One-cycle pulse when `blk_out` holds a new result |
| blk_out | output | BLK_W | Final state of the last run |
| mix_start | output | 1 | One-cycle request to the external mixing engine |
| mix_in | output | BLK_W | Operand for the engine, valid with `mix_start` |
| mix_done | input | 1 | One-cycle answer from the engine |
| mix_out | input | BLK_W | Engine result, valid with `mix_done` |

## Verification
The only fixed timing in the block is local. `mix_start` rises one cycle after the state that requests it is entered. Scratchpad data arrives one cycle after its address. `done` and the new `blk_out` appear in the cycle after the edge that samples the final `mix_done`. The total run length depends on the engine latency and on how many indices are odd. For that reason the bench does not count cycles to the result. It watches `done` on falling clock edges, latches `blk_out` in the same sampling cycle, and then checks that `done` has dropped and that `blk_out` is unchanged twenty cycles later. The engine model records how many passes each instance requested and whether any request overlapped an unfinished one. These counts are compared with figures that the software model derives from the odd indices it encounters.

// File: rtl/romix_pkg.sv
package romix_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FILL_GO,
    S_FILL_WAIT,
    S_RD_ADDR,
    S_RD_DATA,
    S_FIX_WAIT,
    S_MIX_WAIT
  } phase_t;

endpackage

// File: rtl/romix_spad.sv
module romix_spad #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 1024
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  // Simple dual-port array; no reset so it maps to block RAM.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // One cycle of read latency.
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/romix_addr.sv
module romix_addr #(
  parameter int N_LOG2 = 10,
  parameter bit HALF   = 1'b0,
  localparam int ADDR_W = HALF ? N_LOG2 - 1 : N_LOG2
) (
  input  logic              fill_go,
  input  logic              rd_go,
  input  logic [N_LOG2-1:0] idx,
  input  logic [N_LOG2-1:0] j,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              need_fix
);
  assign rd_en = rd_go;

  generate
    if (HALF) begin : g_half
      // Only even fill steps are kept; odd reads fetch their even neighbour.
      assign wr_en    = fill_go && !idx[0];
      assign wr_addr  = idx[N_LOG2-1:1];
      assign rd_addr  = j[N_LOG2-1:1];
      assign need_fix = j[0];
    end else begin : g_full
      assign wr_en    = fill_go;
      assign wr_addr  = idx;
      assign rd_addr  = j;
      assign need_fix = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/romix_cnt.sv
module romix_cnt #(
  parameter int N_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [N_LOG2-1:0] cnt,
  output logic              last
);
  localparam logic [N_LOG2-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign last = (cnt == TOP);

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && last && !clr) |=> (cnt == '0));
endmodule

// File: rtl/scrypt_romix_ctrl.sv
module scrypt_romix_ctrl
  import romix_pkg::*;
#(
  parameter int N_LOG2    = 10,
  parameter int BLK_W     = 1024,
  parameter bit HALF_SPAD = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [BLK_W-1:0] blk_in,
  output logic             done,
  output logic [BLK_W-1:0] blk_out,
  output logic             mix_start,
  output logic [BLK_W-1:0] mix_in,
  input  logic             mix_done,
  input  logic [BLK_W-1:0] mix_out
);
  localparam int ADDR_W  = HALF_SPAD ? N_LOG2 - 1 : N_LOG2;
  localparam int IDX_LSB = BLK_W / 2;

  phase_t            phase;
  logic [BLK_W-1:0]  x_q;
  logic [BLK_W-1:0]  mix_in_q;
  logic [BLK_W-1:0]  out_q;
  logic              mix_start_q;
  logic              done_q;
  logic              fix_q;

  logic [N_LOG2-1:0] cnt;
  logic              last;
  logic              cnt_clr;
  logic              cnt_inc;

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic              need_fix;
  logic [BLK_W-1:0]  rd_data;
  logic [N_LOG2-1:0] j_idx;

  assign cnt_clr = (phase == S_IDLE) && start;
  assign cnt_inc = mix_done && ((phase == S_FILL_WAIT) || (phase == S_MIX_WAIT));
  assign j_idx   = x_q[IDX_LSB +: N_LOG2];

  romix_cnt #(.N_LOG2(N_LOG2)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .inc  (cnt_inc),
    .cnt  (cnt),
    .last (last)
  );

  romix_addr #(.N_LOG2(N_LOG2), .HALF(HALF_SPAD)) u_addr (
    .fill_go  (phase == S_FILL_GO),
    .rd_go    (phase == S_RD_ADDR),
    .idx      (cnt),
    .j        (j_idx),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .need_fix (need_fix)
  );

  romix_spad #(.ADDR_W(ADDR_W), .DATA_W(BLK_W)) u_spad (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (x_q),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= S_IDLE;
      x_q         <= '0;
      mix_in_q    <= '0;
      out_q       <= '0;
      mix_start_q <= 1'b0;
      done_q      <= 1'b0;
      fix_q       <= 1'b0;
    end else begin
      mix_start_q <= 1'b0;
      done_q      <= 1'b0;
      unique case (phase)
        S_IDLE: begin
          if (start) begin
            x_q   <= blk_in;
            phase <= S_FILL_GO;
          end
        end
        S_FILL_GO: begin
          // The scratchpad write of x_q happens in this cycle.
          mix_start_q <= 1'b1;
          mix_in_q    <= x_q;
          phase       <= S_FILL_WAIT;
        end
        S_FILL_WAIT: begin
          if (mix_done) begin
            x_q   <= mix_out;
            phase <= last ? S_RD_ADDR : S_FILL_GO;
          end
        end
        S_RD_ADDR: begin
          fix_q <= need_fix;
          phase <= S_RD_DATA;
        end
        S_RD_DATA: begin
          mix_start_q <= 1'b1;
          if (fix_q) begin
            mix_in_q <= rd_data;
            phase    <= S_FIX_WAIT;
          end else begin
            mix_in_q <= x_q ^ rd_data;
            phase    <= S_MIX_WAIT;
          end
        end
        S_FIX_WAIT: begin
          if (mix_done) begin
            mix_start_q <= 1'b1;
            mix_in_q    <= x_q ^ mix_out;
            phase       <= S_MIX_WAIT;
          end
        end
        S_MIX_WAIT: begin
          if (mix_done) begin
            x_q <= mix_out;
            if (last) begin
              out_q  <= mix_out;
              done_q <= 1'b1;
              phase  <= S_IDLE;
            end else begin
              phase <= S_RD_ADDR;
            end
          end
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign blk_out   = out_q;
  assign mix_start = mix_start_q;
  assign mix_in    = mix_in_q;

  // Outstanding-request tracker used only by the handshake check.
  logic mix_busy;
  always_ff @(posedge clk) begin
    if (rst)            mix_busy <= 1'b0;
    else if (mix_start) mix_busy <= 1'b1;
    else if (mix_done)  mix_busy <= 1'b0;
  end

  // R10
  mix_start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mix_start |=> !mix_start);

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    mix_busy |-> !mix_start);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(blk_out));

  // R6
  done_after_mix_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mix_done));
endmodule

// File: tb/tb_scrypt_romix_ctrl.sv
package tb_mix_pkg;
  // Stand-in mixing function shared by the engine model and the software model.
  function automatic logic [1023:0] mixf(input logic [1023:0] x);
    logic [1023:0] y;
    for (int i = 0; i < 32; i++) begin
      logic [31:0] a, b, c, r;
      a = x[i*32 +: 32];
      b = x[((i + 1) % 32)*32 +: 32];
      c = x[((i + 13) % 32)*32 +: 32];
      r = ((a ^ {b[24:0], b[31:7]}) + c) * 32'h9E37_79B1;
      y[i*32 +: 32] = r ^ {r[15:0], r[31:16]} ^ 32'(i);
    end
    return y;
  endfunction
endpackage

module tb_mix_model (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    lat,
  input  logic          start,
  input  logic [1023:0] din,
  output logic          done,
  output logic [1023:0] dout,
  output int            n_starts,
  output int            n_overlap
);
  logic          busy;
  logic [3:0]    c;
  logic [1023:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; c <= '0; hold <= '0; done <= 1'b0; dout <= '0;
      n_starts <= 0; n_overlap <= 0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (c == 0) begin
          done <= 1'b1;
          dout <= tb_mix_pkg::mixf(hold);
          busy <= 1'b0;
        end else c <= c - 1'b1;
      end
      if (start) begin
        if (busy) n_overlap <= n_overlap + 1;
        busy     <= 1'b1;
        hold     <= din;
        c        <= lat;
        n_starts <= n_starts + 1;
      end
    end
  end
endmodule

module tb_scrypt_romix_ctrl;
  localparam int N_LOG2 = 10;
  localparam int N      = 1 << N_LOG2;
  localparam int BLK_W  = 1024;
  localparam int WD_LIMIT = 190000;

  typedef struct packed { logic [31:0] seed; logic [3:0] lat; } vec_t;
  localparam vec_t VECS [4] = '{
    '{seed: 32'h0000_0001, lat: 4'd0},
    '{seed: 32'hDEAD_BEEF, lat: 4'd3},
    '{seed: 32'h1234_5678, lat: 4'd1},
    '{seed: 32'hFFFF_FFFF, lat: 4'd5}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [BLK_W-1:0] blk_in = '0;
  logic [3:0] lat = '0;

  always #2.5 clk = ~clk;

  logic f_done, h_done, f_ms, h_ms, f_md, h_md;
  logic [BLK_W-1:0] f_out, h_out, f_mi, h_mi, f_mo, h_mo;
  int f_ns, h_ns, f_ov, h_ov;

  scrypt_romix_ctrl #(.N_LOG2(N_LOG2), .BLK_W(BLK_W), .HALF_SPAD(1'b0)) dut (
    .clk(clk), .rst(rst), .start(start), .blk_in(blk_in),
    .done(f_done), .blk_out(f_out),
    .mix_start(f_ms), .mix_in(f_mi), .mix_done(f_md), .mix_out(f_mo));

  scrypt_romix_ctrl #(.N_LOG2(N_LOG2), .BLK_W(BLK_W), .HALF_SPAD(1'b1)) dut_half (
    .clk(clk), .rst(rst), .start(start), .blk_in(blk_in),
    .done(h_done), .blk_out(h_out),
    .mix_start(h_ms), .mix_in(h_mi), .mix_done(h_md), .mix_out(h_mo));

  tb_mix_model u_mf (.clk(clk), .rst(rst), .lat(lat), .start(f_ms), .din(f_mi),
                     .done(f_md), .dout(f_mo), .n_starts(f_ns), .n_overlap(f_ov));
  tb_mix_model u_mh (.clk(clk), .rst(rst), .lat(lat), .start(h_ms), .din(h_mi),
                     .done(h_md), .dout(h_mo), .n_starts(h_ns), .n_overlap(h_ov));

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit timeout = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= WD_LIMIT) timeout <= 1'b1;
  end

  // Done monitors, sampled on falling edges.
  int f_seen = 0, h_seen = 0, f_wide = 0, h_wide = 0;
  logic f_prev = 1'b0, h_prev = 1'b0;
  logic [BLK_W-1:0] f_cap, h_cap;
  always @(negedge clk) begin
    if (f_done) begin f_seen <= f_seen + 1; f_cap <= f_out; end
    if (h_done) begin h_seen <= h_seen + 1; h_cap <= h_out; end
    if (f_done && f_prev) f_wide <= f_wide + 1;
    if (h_done && h_prev) h_wide <= h_wide + 1;
    f_prev <= f_done;
    h_prev <= h_done;
  end

  task automatic chk(input bit ok, input string req, input logic [BLK_W-1:0] act,
                     input logic [BLK_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [BLK_W-1:0] expand(input logic [31:0] seed);
    logic [BLK_W-1:0] b;
    for (int i = 0; i < 32; i++) begin
      logic [31:0] w;
      w = seed ^ (32'h9E37_79B9 * 32'(i + 1));
      w = w ^ (w >> 15) ^ (w << 5);
      b[i*32 +: 32] = w;
    end
    return b;
  endfunction

  // Software model of the memory-hard pass.
  logic [BLK_W-1:0] sw_v [N];
  task automatic sw_romix(input logic [BLK_W-1:0] bin, output logic [BLK_W-1:0] res,
                          output int odd);
    logic [BLK_W-1:0] x;
    x = bin;
    odd = 0;
    for (int i = 0; i < N; i++) begin
      sw_v[i] = x;
      x = tb_mix_pkg::mixf(x);
    end
    for (int i = 0; i < N; i++) begin
      logic [N_LOG2-1:0] j;
      j = x[BLK_W/2 +: N_LOG2];  // R5: low bits of word 16
      if (j[0]) odd++;
      x = tb_mix_pkg::mixf(x ^ sw_v[j]);
    end
    res = x;
  endtask

  initial begin
    logic [BLK_W-1:0] exp_out, stim;
    int odd, fs0, hs0, fn0, hn0, fw0, hw0;

    repeat (4) @(negedge clk);
    // R1: reset state
    chk(f_done == 1'b0 && h_done == 1'b0, "R1 done in reset", BLK_W'(f_done), '0);
    chk(f_ms == 1'b0 && h_ms == 1'b0, "R1 mix_start in reset", BLK_W'(f_ms), '0);
    rst = 1'b0;
    @(negedge clk);
    chk(f_out == '0 && h_out == '0, "R1 blk_out after reset", f_out | h_out, '0);
    chk(f_done == 1'b0 && f_ms == 1'b0 && h_done == 1'b0 && h_ms == 1'b0,
        "R1 outputs idle after reset", BLK_W'({f_done, f_ms, h_done, h_ms}), '0);

    for (int v = 0; v < 4; v++) begin
      if (!timeout) begin
        stim = expand(VECS[v].seed);
        sw_romix(stim, exp_out, odd);
        lat = VECS[v].lat;
        fs0 = f_seen; hs0 = h_seen; fn0 = f_ns; hn0 = h_ns;
        fw0 = f_wide; hw0 = h_wide;
        @(negedge clk);
        blk_in = stim;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        if (v == 1) begin
          // R2: a start during a run must be ignored
          repeat (200) @(negedge clk);
          blk_in = ~stim;
          start  = 1'b1;
          @(negedge clk);
          start  = 1'b0;
          blk_in = '0;
        end
        while ((f_seen == fs0 || h_seen == hs0) && !timeout) @(negedge clk);
        @(negedge clk);
        // R6 full size against software model
        chk(f_cap == exp_out, $sformatf("R6 full result v%0d", v), f_cap, exp_out);
        // R4 R5 R7 half size against software model
        chk(h_cap == exp_out, $sformatf("R7 half result v%0d", v), h_cap, exp_out);
        // R8
        chk(f_cap == h_cap, $sformatf("R8 full vs half v%0d", v), f_cap, h_cap);
        if (v == 1) chk(f_cap == exp_out && f_seen == fs0 + 1,
                        "R2 busy start ignored", f_cap, exp_out);
        // R3: full size uses exactly 2N passes
        chk(f_ns - fn0 == 2 * N, $sformatf("R3 full pass count v%0d", v),
            BLK_W'(f_ns - fn0), BLK_W'(2 * N));
        // R7: half size adds one pass per odd index
        chk(h_ns - hn0 == 2 * N + odd, $sformatf("R7 half pass count v%0d", v),
            BLK_W'(h_ns - hn0), BLK_W'(2 * N + odd));
        // R10: no overlapping requests
        chk(f_ov == 0 && h_ov == 0, $sformatf("R10 overlap v%0d", v),
            BLK_W'(f_ov + h_ov), '0);
        // R9: single-cycle done and held output
        chk(f_wide == fw0 && h_wide == hw0, $sformatf("R9 done width v%0d", v),
            BLK_W'(f_wide - fw0 + h_wide - hw0), '0);
        repeat (20) @(negedge clk);
        chk(f_out == exp_out && h_out == exp_out, $sformatf("R9 output held v%0d", v),
            f_out ^ h_out, '0);
      end
    end

    if (timeout) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WD_LIMIT);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule